// File: doc/BRIEF.md
# Dual-Clock Bus-Matching FIFO with Cross-Domain Flags

This block is a first-in first-out store with two independent clocks. Port A writes full 36-bit long words on clock A. Port B reads on clock B, and its width is chosen at run time: a whole long word, an 18-bit half, or a 9-bit byte. In the narrow modes each long word is handed out in pieces, most significant piece first. A long word counts as removed only when its last piece has been read.

Two status flags are provided, and both are active low. The full flag is registered in the clock-A domain. The almost-empty flag is registered in the clock-B domain and compares the fill level against a fixed offset. Each flag sees the opposite side's pointer through a Gray-coded two-flop synchronizer, so it reacts to activity on the other side after a short, slightly variable delay.

Every access on either port is qualified by four control inputs: an active-low port select, a read/write direction, a mailbox select that must be low, and an enable. Port B has an output register that keeps its last value between qualified reads.

Top module: `xclk_busmatch_fifo`

## Requirements
- R1: A long word is stored on a rising clock-A edge only when csAN is low, rwA is low, mbA is low and enA is high; a write attempt with any one of these qualifiers off leaves the contents unchanged.
- R2: A read happens on a rising clock-B edge only when csBN is low, rwB is high, mbB is low and enB is high; otherwise dataOut holds its value.
- R3: fullN goes low once DEPTH long words are stored. While fullN is low, writes are ignored and do not disturb stored data or pointers.
- R4: With a narrow read width, fullN returns high (a few clock-A cycles later) only after the read of the last piece of the oldest long word. Reads of earlier pieces leave fullN low.
- R5: aeN is low while the number of stored long words is AE_OFFSET or fewer. It goes high (a few clock-B cycles after the write) once the count reaches AE_OFFSET+1.
- R6: With a narrow read width, aeN is driven low only by the read of the last piece of a long word. Reads of earlier pieces leave it high.
- R7: With rdWidth = 2'b00 (or 2'b11), each qualified read places the next whole 36-bit long word on dataOut, in write order.
- R8: With rdWidth = 2'b01, each long word is read as two pieces: bits 35:18 first, then bits 17:0. Each piece appears on dataOut[17:0], and dataOut[35:18] reads zero.
- R9: With rdWidth = 2'b10, each long word is read as four bytes: bits 35:27, then 26:18, then 17:9, then 8:0. Each byte appears on dataOut[8:0], and the upper bits read zero.
- R10: A read while the FIFO is empty is ignored: dataOut keeps its value and no data is lost.
- R11: While rstN is low (asynchronous), the pointers and the piece counter are cleared, fullN is high, aeN is low and dataOut is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Write-side clock |
| clkB | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csAN | input | 1 | Port A select, active low |
| rwA | input | 1 | Port A direction, low = write |
| mbA | input | 1 | Port A mailbox select, must be low for FIFO access |
| enA | input | 1 | Port A enable |
| dataIn | input | 36 | Long word to write |
| csBN | input | 1 | Port B select, active low |
| rwB | input | 1 | Port B direction, high = read |
| mbB | input | 1 | Port B mailbox select, must be low for FIFO access |
| enB | input | 1 | Port B enable |
| rdWidth | input | 2 | Read width: 00 long, 01 half, 10 byte, 11 long |
| dataOut | output | 36 | Port B output register |
| fullN | output | 1 | Full flag, active low, clock-A domain |
| aeN | output | 1 | Almost-empty flag, active low, clock-B domain |

## Verification
The assertions assume that rdWidth only changes while no long word is partly read, and that reset is applied to both domains together. The stimulus follows these rules: it changes the width only right after a reset, and it drives every input at the falling edge of the clock that samples it. Flag checks wait several cycles of both clocks after the last access. This covers the variable synchronizer delay and never depends on the exact clock-to-clock phase.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

  typedef enum logic [1:0] {
    RD_LONG = 2'b00,
    RD_HALF = 2'b01,
    RD_BYTE = 2'b10,
    RD_ALT  = 2'b11
  } rdMode_e;

  typedef struct packed {
    logic    wrEn;
    logic    rdEn;
    logic [1:0] pieceIdx;
    rdMode_e rdMode;
  } bmfStrobe_t;

endpackage

// File: rtl/bmf_ctrl.sv
module bmf_ctrl
  import bmf_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int AE_OFFSET = 8
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic              rdReq,
  input  rdMode_e           rdMode,
  output bmfStrobe_t        strb,
  output logic              lastPiece,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullN,
  output logic              aeN
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] AE_LIM = AE_OFFSET[PW-1:0];

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic [PW-1:0] wrBin, wrGray, wrBinNext, wrGrayNext;
  logic [PW-1:0] rdGrayA1, rdGrayA2;
  logic          wrEn;

  assign wrEn       = wrReq & fullN;
  assign wrBinNext  = wrBin + {{(PW-1){1'b0}}, wrEn};
  assign wrGrayNext = bin2gray(wrBinNext);

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayA1 <= '0;
      rdGrayA2 <= '0;
      fullN    <= 1'b1;
    end else begin
      wrBin    <= wrBinNext;
      wrGray   <= wrGrayNext;
      rdGrayA1 <= rdGray;
      rdGrayA2 <= rdGrayA1;
      fullN    <= !(wrGrayNext == {~rdGrayA2[PW-1:PW-2], rdGrayA2[PW-3:0]});
    end
  end

  // read domain
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] wrGrayB1, wrGrayB2, fill;
  logic [1:0]    pieceIdx;
  logic          rdEn, rdEmpty;

  always_comb begin
    unique case (rdMode)
      RD_HALF: lastPiece = (pieceIdx >= 2'd1);
      RD_BYTE: lastPiece = (pieceIdx == 2'd3);
      default: lastPiece = 1'b1;
    endcase
  end

  assign rdEmpty   = (rdGray == wrGrayB2);
  assign rdEn      = rdReq & !rdEmpty;
  assign rdBinNext = rdBin + {{(PW-1){1'b0}}, rdEn & lastPiece};
  assign fill      = gray2bin(wrGrayB2) - rdBinNext;

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayB1 <= '0;
      wrGrayB2 <= '0;
      pieceIdx <= '0;
      aeN      <= 1'b0;
    end else begin
      rdBin    <= rdBinNext;
      rdGray   <= bin2gray(rdBinNext);
      wrGrayB1 <= wrGray;
      wrGrayB2 <= wrGrayB1;
      if (rdEn) pieceIdx <= lastPiece ? 2'd0 : pieceIdx + 2'd1;
      aeN      <= (fill > AE_LIM);
    end
  end

  assign wrAddr        = wrBin[ADDR_W-1:0];
  assign rdAddr        = rdBin[ADDR_W-1:0];
  assign strb.wrEn     = wrEn;
  assign strb.rdEn     = rdEn;
  assign strb.pieceIdx = pieceIdx;
  assign strb.rdMode   = rdMode;
endmodule

// File: rtl/bmf_datapath.sv
module bmf_datapath
  import bmf_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  bmfStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int HW = DATA_W / 2;
  localparam int QW = DATA_W / 4;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memWord, shifted, piece;

  always_ff @(posedge clkA) begin
    if (strb.wrEn) mem[wrAddr] <= dataIn;
  end

  assign memWord = mem[rdAddr];

  always_comb begin
    unique case (strb.rdMode)
      RD_HALF: begin
        shifted = strb.pieceIdx[0] ? memWord : (memWord >> HW);
        piece   = {{(DATA_W-HW){1'b0}}, shifted[HW-1:0]};
      end
      RD_BYTE: begin
        shifted = memWord >> (QW * (3 - int'(strb.pieceIdx)));
        piece   = {{(DATA_W-QW){1'b0}}, shifted[QW-1:0]};
      end
      default: begin
        shifted = memWord;
        piece   = memWord;
      end
    endcase
  end

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)          dataOut <= '0;
    else if (strb.rdEn) dataOut <= piece;
  end
endmodule

// File: rtl/xclk_busmatch_fifo.sv
module xclk_busmatch_fifo
  import bmf_pkg::*;
#(
  parameter int DATA_W    = 36,
  parameter int DEPTH     = 2048,
  parameter int AE_OFFSET = 8
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              csAN,
  input  logic              rwA,
  input  logic              mbA,
  input  logic              enA,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              csBN,
  input  logic              rwB,
  input  logic              mbB,
  input  logic              enB,
  input  logic [1:0]        rdWidth,
  output logic [DATA_W-1:0] dataOut,
  output logic              fullN,
  output logic              aeN
);
  localparam int ADDR_W = $clog2(DEPTH);

  bmfStrobe_t        strb;
  logic              lastPiece;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              wrReq, rdReq;

  assign wrReq = !csAN && !rwA && !mbA && enA;
  assign rdReq = !csBN &&  rwB && !mbB && enB;

  bmf_ctrl #(.ADDR_W(ADDR_W), .AE_OFFSET(AE_OFFSET)) uCtrl (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .wrReq(wrReq), .rdReq(rdReq), .rdMode(rdMode_e'(rdWidth)),
    .strb(strb), .lastPiece(lastPiece),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .aeN(aeN)
  );

  bmf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uData (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/bmf_checker.sv
module bmf_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clkA,
  input logic              clkB,
  input logic              rstN,
  input logic              csAN,
  input logic              rwA,
  input logic              mbA,
  input logic              enA,
  input logic              csBN,
  input logic              rwB,
  input logic              mbB,
  input logic              enB,
  input logic              fullN,
  input logic              aeN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              lastPiece,
  input logic [ADDR_W-1:0] rdAddr
);
  assert_write_qual_R1: assert property (@(posedge clkA) disable iff (!rstN)
    (csAN || rwA || mbA || !enA) |-> !wrEn);

  assert_read_qual_R2: assert property (@(posedge clkB) disable iff (!rstN)
    (csBN || !rwB || mbB || !enB) |-> !rdEn);

  assert_no_write_when_full_R3: assert property (@(posedge clkA) disable iff (!rstN)
    !fullN |-> !wrEn);

  assert_full_by_write_R3: assert property (@(posedge clkA) disable iff (!rstN)
    $fell(fullN) |-> $past(wrEn));

  assert_partial_keeps_slot_R4: assert property (@(posedge clkB) disable iff (!rstN)
    (rdEn && !lastPiece) |=> $stable(rdAddr));

  assert_ae_by_last_piece_R6: assert property (@(posedge clkB) disable iff (!rstN)
    $fell(aeN) |-> $past(rdEn && lastPiece));
endmodule

bind xclk_busmatch_fifo bmf_checker #(.ADDR_W(ADDR_W)) uChk (
  .clkA(clkA), .clkB(clkB), .rstN(rstN),
  .csAN(csAN), .rwA(rwA), .mbA(mbA), .enA(enA),
  .csBN(csBN), .rwB(rwB), .mbB(mbB), .enB(enB),
  .fullN(fullN), .aeN(aeN),
  .wrEn(strb.wrEn), .rdEn(strb.rdEn),
  .lastPiece(lastPiece), .rdAddr(rdAddr)
);

// File: tb/sim_xclk_busmatch_fifo.sv
module sim_xclk_busmatch_fifo;
  localparam int CLKA_PERIOD = 10;
  localparam int CLKB_PERIOD = 14;
  localparam int DEPTH = 16;
  localparam int AEOFF = 3;

  logic clkA = 0, clkB = 0, rstN = 0;
  logic csAN = 1, rwA = 1, mbA = 0, enA = 0;
  logic csBN = 1, rwB = 0, mbB = 0, enB = 0;
  logic [35:0] dataIn = '0;
  logic [1:0]  rdWidth = 2'b00;
  logic [35:0] dataOut;
  logic fullN, aeN;
  int checks = 0, errors = 0;

  always #(CLKA_PERIOD/2) clkA = ~clkA;
  always #(CLKB_PERIOD/2) clkB = ~clkB;

  xclk_busmatch_fifo #(.DATA_W(36), .DEPTH(DEPTH), .AE_OFFSET(AEOFF)) u0 (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .csAN(csAN), .rwA(rwA), .mbA(mbA), .enA(enA), .dataIn(dataIn),
    .csBN(csBN), .rwB(rwB), .mbB(mbB), .enB(enB), .rdWidth(rdWidth),
    .dataOut(dataOut), .fullN(fullN), .aeN(aeN)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] mode);
    rstN = 0;
    rdWidth = mode;
    #(3*CLKB_PERIOD);
    @(negedge clkA) rstN = 1;
    repeat (2) @(negedge clkB);
  endtask

  task automatic settle();
    repeat (6) @(negedge clkA);
    repeat (6) @(negedge clkB);
  endtask

  task automatic pushRaw(input logic [35:0] d, input logic cs, input logic rw, input logic mb);
    @(negedge clkA);
    csAN = cs; rwA = rw; mbA = mb; enA = 1; dataIn = d;
    @(negedge clkA);
    csAN = 1; rwA = 1; mbA = 0; enA = 0;
  endtask

  task automatic push(input logic [35:0] d);
    pushRaw(d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic popRaw(input logic cs, input logic rw, input logic mb);
    @(negedge clkB);
    csBN = cs; rwB = rw; mbB = mb; enB = 1;
    @(negedge clkB);
    csBN = 1; rwB = 0; mbB = 0; enB = 0;
  endtask

  task automatic pop();
    popRaw(1'b0, 1'b1, 1'b0);
  endtask

  task automatic tReset();
    doReset(2'b00);
    check("R11 fullN", {35'd0, fullN}, 36'd1);
    check("R11 aeN", {35'd0, aeN}, 36'd0);
    check("R11 dataOut", dataOut, 36'd0);
  endtask

  task automatic tLong();
    doReset(2'b00);
    push(36'hA11112222); push(36'hB33334444);
    settle();
    pop();
    check("R7 first long", dataOut, 36'hA11112222);
    popRaw(1'b1, 1'b1, 1'b0);
    check("R2 csBN high holds", dataOut, 36'hA11112222);
    popRaw(1'b0, 1'b0, 1'b0);
    check("R2 rwB low holds", dataOut, 36'hA11112222);
    popRaw(1'b0, 1'b1, 1'b1);
    check("R2 mbB high holds", dataOut, 36'hA11112222);
    pop();
    check("R7 second long", dataOut, 36'hB33334444);
  endtask

  task automatic tHalf();
    logic [35:0] w = 36'h9ABCDE123;
    doReset(2'b01);
    push(w);
    settle();
    pop();
    check("R8 upper half", dataOut, {18'd0, w[35:18]});
    pop();
    check("R8 lower half", dataOut, {18'd0, w[17:0]});
  endtask

  task automatic tByte();
    logic [35:0] w = 36'h5F0E1D2C3;
    doReset(2'b10);
    push(w); push(36'h0);
    settle();
    for (int i = 3; i >= 0; i--) begin
      pop();
      check("R9 byte order", dataOut, {27'd0, w[9*i +: 9]});
    end
  endtask

  task automatic tWriteQual();
    doReset(2'b00);
    pushRaw(36'h111111111, 1'b1, 1'b0, 1'b0);
    pushRaw(36'h222222222, 1'b0, 1'b1, 1'b0);
    pushRaw(36'h333333333, 1'b0, 1'b0, 1'b1);
    settle();
    pop();
    check("R1 unqualified writes ignored", dataOut, 36'd0);
    push(36'h444444444);
    settle();
    pop();
    check("R1 qualified write", dataOut, 36'h444444444);
  endtask

  task automatic tEmpty();
    doReset(2'b00);
    pop();
    check("R10 read on empty at reset", dataOut, 36'd0);
    push(36'hCAFE01234);
    settle();
    pop();
    check("R10 data after empty read", dataOut, 36'hCAFE01234);
    pop();
    check("R10 read on empty holds", dataOut, 36'hCAFE01234);
  endtask

  task automatic tFull();
    doReset(2'b00);
    for (int i = 0; i < DEPTH - 1; i++) push(36'h100 + 36'(i));
    settle();
    check("R3 not full at DEPTH-1", {35'd0, fullN}, 36'd1);
    push(36'h100 + 36'(DEPTH - 1));
    settle();
    check("R3 full at DEPTH", {35'd0, fullN}, 36'd0);
    push(36'hBAD);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      check("R3 order after full", dataOut, 36'h100 + 36'(i));
    end
    pop();
    check("R3 overflow write dropped", dataOut, 36'h100 + 36'(DEPTH - 1));
  endtask

  task automatic tFullRelease();
    doReset(2'b10);
    for (int i = 0; i < DEPTH; i++) push(36'h200 + 36'(i));
    settle();
    check("R4 full before reads", {35'd0, fullN}, 36'd0);
    repeat (3) pop();
    settle();
    check("R4 full after partial bytes", {35'd0, fullN}, 36'd0);
    pop();
    settle();
    check("R4 released by last byte", {35'd0, fullN}, 36'd1);
  endtask

  task automatic tAlmostEmpty();
    doReset(2'b01);
    for (int i = 0; i < AEOFF; i++) push(36'h300 + 36'(i));
    settle();
    check("R5 ae low at offset", {35'd0, aeN}, 36'd0);
    push(36'h3FF);
    settle();
    check("R5 ae high above offset", {35'd0, aeN}, 36'd1);
    pop();
    settle();
    check("R6 ae held after first half", {35'd0, aeN}, 36'd1);
    pop();
    settle();
    check("R6 ae low after last half", {35'd0, aeN}, 36'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clkA);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tReset();
    tLong();
    tHalf();
    tByte();
    tWriteQual();
    tEmpty();
    tFull();
    tFullRelease();
    tAlmostEmpty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule